// File: doc/BRIEF.md
# Sixteen-Line Interrupt Aggregator

This block collects up to sixteen external interrupt sources and presents them to a host processor as a single active-high level interrupt. Each source passes through a two-flop synchronizer. A rising edge on the synchronized line sets a sticky pending bit. The pending bit stays set until the host clears it, and it is set whatever the line's enable bit holds. The output is raised while any pending bit is also enabled.

The host reaches the block through a 16-bit register window on a simple synchronous strobe bus. The bus has one byte address shared by reads and writes, a write strobe and a read strobe. Read data appears on the cycle after the read strobe.

Four offsets are decoded:
- 0x16 reads the pending bits. A write clears every bit written as one.
- 0x18 reads the synchronized level of the inputs, with no latching.
- 0x1A sets enable bits written as one. A read returns the enable mask.
- 0x1C clears enable bits written as one. A read also returns the enable mask.

The enable mask has no plain write path. It changes only through the set and clear offsets. A startup routine therefore clears every enable bit and then every pending bit.

Top module: `irqx_expander`

## Requirements
- R1: After reset the pending bits and enable mask are all zero, `irq_out` is low, and every register reads 0x0000.
- R2: A 0-to-1 transition on `irq_src[i]` sets pending bit i two clock edges after the edge that first samples it. The bit stays set after the source falls again.
- R3: A write to offset 0x16 clears each pending bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R4: A read of offset 0x18 returns the inputs as sampled through the two-flop synchronizer, with no latching.
- R5: A write to offset 0x1A sets each enable bit whose data bit is 1, leaving the others. A read of 0x1A returns the enable mask.
- R6: A write to offset 0x1C clears each enable bit whose data bit is 1, leaving the others. A read of 0x1C returns the same enable mask as 0x1A.
- R7: `irq_out` is high exactly while some bit is both pending and enabled. It follows the register state with no added delay.
- R8: If a new rising edge and a host clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: Pending bits are captured whether or not the line is enabled. Enabling a line that already has a pending bit raises `irq_out` on the edge that takes the write.
- R10: Reads of any other offset return 0x0000, and writes to any other offset change no state.
- R11: Read data is registered. It presents the value addressed by a read strobe on the cycle after that strobe, and it holds until the next strobe.
- R12: Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16 leaves every line disabled, every pending bit clear and `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 16 | Asynchronous interrupt source lines |
| bus_addr | input | 8 | Byte address for read or write |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Active-high level interrupt to host |

## Verification
The bound checker checks the per-cycle rules on every cycle:
- pending bits never drop without a clear write;
- the enable mask moves only on the set or clear offsets, and in the written direction;
- a same-cycle edge beats a clear;
- an all-zero mask keeps the output low.

The bench scenarios are needed for the rest:
- the two-edge synchronizer delay to both the live and pending registers;
- the one-cycle read latency and read-data hold;
- enabling an already-pending line;
- the full startup sequence;
- zero reads from unmapped offsets.

A reference model in the bench also tracks a long random mix of source toggles and bus traffic.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    // register selected by a bus address
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_PEND = 3'd1,
        SEL_LIVE = 3'd2,
        SEL_ENSET = 3'd3,
        SEL_ENCLR = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/irqx_capture.sv
module irqx_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] clear_i,
    output logic [W-1:0] pending_o,
    output logic [W-1:0] edge_o
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] pend;
    } cap_t;

    cap_t st_d, st_q;
    logic [W-1:0] rise;

    // one slice per line: a new edge beats a same-cycle clear
    for (genvar g = 0; g < W; g++) begin : g_line
        assign rise[g] = level_i[g] & ~st_q.prev[g];
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        st_d.pend = (st_q.pend & ~clear_i) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = st_q.pend;
    assign edge_o    = rise;

endmodule

// File: rtl/irqx_mask.sv
module irqx_mask #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] mask_o
);

    typedef struct packed {
        logic [W-1:0] en;
    } mask_t;

    mask_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = (st_q.en | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.en;

endmodule

// File: rtl/irqx_expander.sv
module irqx_expander
    import irqx_pkg::*;
#(
    parameter int          N_LINES   = 16,
    parameter int          ADDR_W    = 8,
    parameter int          SYNC_STG  = 2,
    parameter logic [7:0]  OFF_PEND  = 8'h16,
    parameter logic [7:0]  OFF_LIVE  = 8'h18,
    parameter logic [7:0]  OFF_ENSET = 8'h1A,
    parameter logic [7:0]  OFF_ENCLR = 8'h1C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_src,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    output logic               irq_out
);

    localparam int DW = N_LINES;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        reg_sel_e r;
        r = SEL_NONE;
        if (a == ADDR_W'(OFF_PEND))  r = SEL_PEND;
        if (a == ADDR_W'(OFF_LIVE))  r = SEL_LIVE;
        if (a == ADDR_W'(OFF_ENSET)) r = SEL_ENSET;
        if (a == ADDR_W'(OFF_ENCLR)) r = SEL_ENCLR;
        return r;
    endfunction

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_t;

    reg_sel_e      sel;
    logic [DW-1:0] live;
    logic [DW-1:0] status_q;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] edge_vec;
    logic [DW-1:0] pend_clr;
    logic [DW-1:0] en_set;
    logic [DW-1:0] en_clr;
    rd_t           rd_d, rd_q;

    assign sel      = decode(bus_addr);
    assign pend_clr = (bus_wr && sel == SEL_PEND)  ? bus_wdata : '0;
    assign en_set   = (bus_wr && sel == SEL_ENSET) ? bus_wdata : '0;
    assign en_clr   = (bus_wr && sel == SEL_ENCLR) ? bus_wdata : '0;

    irqx_sync #(.W(DW), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_src),
        .sync_o  (live)
    );

    irqx_capture #(.W(DW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (live),
        .clear_i   (pend_clr),
        .pending_o (status_q),
        .edge_o    (edge_vec)
    );

    irqx_mask #(.W(DW)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (en_set),
        .clr_i  (en_clr),
        .mask_o (mask_q)
    );

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) begin
            unique case (sel)
                SEL_PEND:  rd_d.rdata = status_q;
                SEL_LIVE:  rd_d.rdata = live;
                SEL_ENSET: rd_d.rdata = mask_q;
                SEL_ENCLR: rd_d.rdata = mask_q;
                default:   rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;
    assign irq_out   = |(status_q & mask_q);

endmodule

// File: rtl/irqx_checker.sv
module irqx_checker #(
    parameter int         N_LINES   = 16,
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] OFF_PEND  = 8'h16,
    parameter logic [7:0] OFF_ENSET = 8'h1A,
    parameter logic [7:0] OFF_ENCLR = 8'h1C
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [N_LINES-1:0] bus_wdata,
    input logic [N_LINES-1:0] status,
    input logic [N_LINES-1:0] mask,
    input logic [N_LINES-1:0] edges,
    input logic               irq_out
);

    logic wr_pend, wr_set, wr_clr;
    assign wr_pend = bus_wr && (bus_addr == ADDR_W'(OFF_PEND));
    assign wr_set  = bus_wr && (bus_addr == ADDR_W'(OFF_ENSET));
    assign wr_clr  = bus_wr && (bus_addr == ADDR_W'(OFF_ENCLR));

    // R2: a pending bit never drops without a clear write
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pend |=> ((status & $past(status)) == $past(status)));

    // R5 / R10: mask only changes through its two offsets
    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr) |=> $stable(mask));

    assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

    assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask & $past(bus_wdata)) == '0));

    // R8: a same-cycle edge survives a clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edges != '0) |=> ((status & $past(edges)) == $past(edges)));

    // R7: nothing enabled means no interrupt
    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_out);

endmodule

bind irqx_expander irqx_checker #(
    .N_LINES   (N_LINES),
    .ADDR_W    (ADDR_W),
    .OFF_PEND  (OFF_PEND),
    .OFF_ENSET (OFF_ENSET),
    .OFF_ENCLR (OFF_ENCLR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .status    (status_q),
    .mask      (mask_q),
    .edges     (edge_vec),
    .irq_out   (irq_out)
);

// File: tb/irqx_expander_test.sv
`timescale 1ns/1ps
module irqx_expander_test;

    localparam logic [7:0] A_PEND = 8'h16;
    localparam logic [7:0] A_LIVE = 8'h18;
    localparam logic [7:0] A_SET  = 8'h1A;
    localparam logic [7:0] A_CLR  = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_src = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;

    int n_checks = 0;
    int n_fail = 0;
    bit model_on = 1'b0;

    always #2.5 clk = ~clk;

    irqx_expander uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // reference model built from the requirements
    logic [15:0] m_s1, m_s2, m_prev, m_pend, m_en, m_rd;

    function automatic logic [15:0] model_read(input logic [7:0] a, input logic [15:0] pend,
                                              input logic [15:0] live, input logic [15:0] en);
        if (a == A_PEND) return pend;
        if (a == A_LIVE) return live;
        if (a == A_SET || a == A_CLR) return en;
        return 16'h0000;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0; m_en <= '0; m_rd <= '0;
        end else begin
            m_s1   <= irq_src;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_pend <= (m_pend & ~((bus_wr && bus_addr == A_PEND) ? bus_wdata : 16'h0))
                      | (m_s2 & ~m_prev);
            if (bus_wr && bus_addr == A_SET) m_en <= m_en | bus_wdata;
            if (bus_wr && bus_addr == A_CLR) m_en <= m_en & ~bus_wdata;
            if (bus_rd) m_rd <= model_read(bus_addr, m_pend, m_s2, m_en);
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1: reset state
        check("R1 irq", {15'd0, irq_out}, 16'h0);
        rd(A_PEND, v); check("R1 pend", v, 16'h0);
        rd(A_SET, v);  check("R1 mask", v, 16'h0);
        rd(A_LIVE, v); check("R1 live", v, 16'h0);

        // R2 / R4 / R9: edge capture with mask off
        irq_src = 16'h0011;
        cyc(1);
        rd(A_LIVE, v); check("R4 live after one edge", v, 16'h0000);
        rd(A_LIVE, v); check("R4 live synced", v, 16'h0011);
        rd(A_PEND, v); check("R2 pend set", v, 16'h0011);
        check("R9 masked irq low", {15'd0, irq_out}, 16'h0);
        irq_src = 16'h0000;
        cyc(4);
        rd(A_PEND, v); check("R2 pend sticky", v, 16'h0011);

        // R9 / R5: enabling a pending line raises irq at once
        wr(A_SET, 16'h0010);
        check("R9 irq after enable", {15'd0, irq_out}, 16'h1);
        rd(A_SET, v); check("R5 mask read", v, 16'h0010);
        wr(A_SET, 16'h8000);
        rd(A_SET, v); check("R5 mask or", v, 16'h8010);

        // R3: partial clear
        wr(A_PEND, 16'h0001);
        rd(A_PEND, v); check("R3 partial clear", v, 16'h0010);
        check("R7 irq still high", {15'd0, irq_out}, 16'h1);

        // R6 / R7: disable line
        wr(A_CLR, 16'h0010);
        check("R7 irq low after disable", {15'd0, irq_out}, 16'h0);
        rd(A_CLR, v); check("R6 mask via clr offset", v, 16'h8000);

        // R10: unmapped read and write
        wr(8'h1E, 16'hFFFF);
        rd(8'h1E, v); check("R10 unmapped read", v, 16'h0);
        rd(A_SET, v); check("R10 mask untouched", v, 16'h8000);
        rd(A_PEND, v); check("R10 pend untouched", v, 16'h0010);

        // R11: read data holds without strobe
        cyc(3);
        check("R11 hold", bus_rdata, 16'h0010);

        // R8: edge and clear in the same cycle
        wr(A_PEND, 16'hFFFF);
        irq_src = 16'h0100;
        cyc(2);
        wr(A_PEND, 16'h0100);
        rd(A_PEND, v); check("R8 set wins", v, 16'h0100);
        irq_src = 16'h0000;

        // R12: startup sequence
        wr(A_SET, 16'hFFFF);
        wr(A_CLR, 16'hFFFF);
        wr(A_PEND, 16'hFFFF);
        rd(A_SET, v);  check("R12 mask zero", v, 16'h0);
        rd(A_PEND, v); check("R12 pend zero", v, 16'h0);
        check("R12 irq low", {15'd0, irq_out}, 16'h0);

        // random traffic against the model (R2..R11)
        model_on = 1'b1;
        for (int k = 0; k < 4000; k++) begin
            int op;
            int pick;
            logic [7:0] a;
            irq_src = irq_src ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
            pick = int'($urandom_range(0, 4));
            case (pick)
                0: a = A_PEND;
                1: a = A_LIVE;
                2: a = A_SET;
                3: a = A_CLR;
                default: a = 8'($urandom);
            endcase
            op = int'($urandom_range(0, 3));
            bus_addr  = a;
            bus_wdata = 16'($urandom);
            bus_wr    = (op == 1);
            bus_rd    = (op >= 2);
            @(negedge clk);
            check("R7 random irq", {15'd0, irq_out}, {15'd0, |(m_pend & m_en)});
            check("R11 random rdata", bus_rdata, m_rd);
        end
        bus_wr = 1'b0; bus_rd = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule